// File: doc/BRIEF.md
# Image Decoder Control Register File

This block is the host-facing register bank of an image decoder core. It is a 32-bit Wishbone slave with zero wait states. Through it the host sets the interrupt enables, the crop window (two corners in X and Y), the base address and length of the compressed source, and the geometry of the output buffer (base, limit, offset and line width). The block also lets the host read the values that the decoding datapath drives: eight event flags, the image width and height, and the current output write pointer.

Writes are shaped per register. X coordinates and the line width always hold an even value. Output-buffer addresses always hold a word-aligned value. The remaining registers take the bus bits as they come. The event flags are cleared by write-1-to-clear commands, and some command bits clear a whole group of flags at once. A flag that the datapath sets in the same cycle as a clear stays set. The interrupt output is high while any enabled flag is set.

Top module: `imgdec_regfile`

## Requirements
- R1: Each access (`wb_cyc_i` and `wb_stb_i` high while `wb_ack_o` is low) gives `wb_ack_o` high for exactly one cycle, in the cycle after the request. A write takes effect at the same clock edge that raises the acknowledge.
- R2: Register word offsets (`wb_adr_i`): 0 FLAGS, 1 IRQ_EN, 2 IMG_W, 3 IMG_H, 4 CROP_X0, 5 CROP_Y0, 6 CROP_X1, 7 CROP_Y1, 8 SRC_BASE, 9 SRC_LEN, 10 DST_BASE, 11 DST_LIMIT, 12 DST_OFFSET, 13 DST_WIDTH, 14 DST_PTR. Offset 15 is unmapped and reads 0.
- R3: Flags are numbered 1 to 8. `flag_set_i[i]` sets flag i+1. A FLAGS read returns flag i+1 in data bit i and zero in bits 31..8.
- R4: In a FLAGS write, data bit 8 clears flags 6..1, and data bit 7 clears flag 8 together with flags 6..1.
- R5: In a FLAGS write, data bit 2 clears flag 2 and data bit 1 clears flag 1. Any flag that no set command bit names keeps its value, and flag 7 is only cleared by reset.
- R6: A set pulse wins over a clear command that arrives in the same cycle.
- R7: CROP_X0, CROP_X1 and DST_WIDTH are 16 bits wide. They store bus bits 15..1, and their bit 0 is always 0.
- R8: DST_BASE, DST_LIMIT and DST_OFFSET store bus bits 31..2, and their bits 1..0 are always 0.
- R9: CROP_Y0 and CROP_Y1 store bus bits 15..0. SRC_BASE and SRC_LEN store all 32 bits. Each 16-bit register reads back zero-extended.
- R10: IRQ_EN stores bus bits 8..1 as the enables for flags 8..1 and drops bus bit 0. It reads back in data bits 7..0 in the same layout as FLAGS.
- R11: IMG_W, IMG_H and DST_PTR read the datapath inputs. A write to these offsets or to offset 15 is acknowledged and changes no register.
- R12: `irq_o` is high exactly when some flag and its enable are both 1.
- R13: After reset, all registers and flags are 0, and `wb_ack_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | 1 for a write, 0 for a read |
| wb_adr_i | input | 4 | Word offset of the register |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid while `wb_ack_o` is high |
| wb_ack_o | output | 1 | Access acknowledge |
| flag_set_i | input | 8 | Per-flag set pulses from the datapath |
| img_w_i | input | 16 | Image width from the datapath |
| img_h_i | input | 16 | Image height from the datapath |
| dst_ptr_i | input | 32 | Current output write pointer |
| crop_x0_o | output | 16 | Crop start X |
| crop_y0_o | output | 16 | Crop start Y |
| crop_x1_o | output | 16 | Crop end X |
| crop_y1_o | output | 16 | Crop end Y |
| src_base_o | output | 32 | Source read address |
| src_len_o | output | 32 | Source read length |
| dst_base_o | output | 32 | Output buffer base |
| dst_limit_o | output | 32 | Output buffer limit |
| dst_offset_o | output | 32 | Output buffer offset |
| dst_width_o | output | 16 | Output line width |
| irq_o | output | 1 | Interrupt request |

## Verification
The flag clear logic is tested with all eight flags set, and each clear command bit is then written on its own. Because the two group bits differ only in flag 8, and the single bits each name one flag, a wrong group boundary shows up in the readback. The shaped writes use an all-ones word and an odd, irregular word. The all-ones word shows which low bits are forced to zero. The irregular word shows whether the stored bits are taken from the right bus positions. A set pulse that arrives together with a group clear shows whether set wins over clear. Enabling one flag and then pulsing another flag shows whether the interrupt follows only the enabled flags.

// File: rtl/imgdec_regfile_pkg.sv
// Package: widths, register offsets and the flag clear rule of the
// decoder control register file. Assumes an 8-flag, 32-bit layout.
package imgdec_regfile_pkg;

    localparam int BUS_W  = 32;
    localparam int HALF_W = 16;
    localparam int FLAG_N = 8;
    localparam int ADR_W  = 4;

    localparam int OFS_FLAGS      = 0;
    localparam int OFS_IRQ_EN     = 1;
    localparam int OFS_IMG_W      = 2;
    localparam int OFS_IMG_H      = 3;
    localparam int OFS_CROP_X0    = 4;
    localparam int OFS_CROP_Y0    = 5;
    localparam int OFS_CROP_X1    = 6;
    localparam int OFS_CROP_Y1    = 7;
    localparam int OFS_SRC_BASE   = 8;
    localparam int OFS_SRC_LEN    = 9;
    localparam int OFS_DST_BASE   = 10;
    localparam int OFS_DST_LIMIT  = 11;
    localparam int OFS_DST_OFFSET = 12;
    localparam int OFS_DST_WIDTH  = 13;
    localparam int OFS_DST_PTR    = 14;

    // Clear command bits, as picked out of the write word.
    typedef struct packed {
        logic grp_a;   // bus bit 8: flags 6..1
        logic grp_b;   // bus bit 7: flag 8 and flags 6..1
        logic one_2;   // bus bit 2: flag 2
        logic one_1;   // bus bit 1: flag 1
    } flag_clr_t;

    // Turn a clear command into a per-flag mask (index i = flag i+1).
    function automatic logic [FLAG_N-1:0] flag_clear_mask(flag_clr_t c);
        logic [FLAG_N-1:0] m;
        m = '0;
        if (c.grp_a) m[5:0] = '1;
        if (c.grp_b) begin
            m[5:0] = '1;
            m[7]   = 1'b1;
        end
        if (c.one_2) m[1] = 1'b1;
        if (c.one_1) m[0] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/imgdec_bus_front.sv
// Bus front: accepts single Wishbone accesses with zero wait states.
// Assumes the master drops its strobe or starts a new access after each
// acknowledge. Read data is registered together with the acknowledge.
module imgdec_bus_front #(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_i,
    input  logic             stb_i,
    input  logic             we_i,
    input  logic [BUS_W-1:0] rd_data_i,
    output logic             req_wr_o,
    output logic             ack_o,
    output logic [BUS_W-1:0] dat_o
);
    logic req;

    // New request when a strobe is seen and no acknowledge is pending.
    always_comb begin
        req      = cyc_i && stb_i && !ack_o;
        req_wr_o = req && we_i;
    end

    // Acknowledge each request one cycle later and capture read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o <= 1'b0;
            dat_o <= '0;
        end else begin
            ack_o <= req;
            dat_o <= (req && !we_i) ? rd_data_i : '0;
        end
    end
endmodule

// File: rtl/imgdec_flag_bank.sv
// Event flag bank: datapath set pulses and grouped write-1-to-clear
// commands from the host. A set wins over a clear in the same cycle.
module imgdec_flag_bank
    import imgdec_regfile_pkg::*;
#(
    parameter int FLAG_W = FLAG_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_we_i,
    input  flag_clr_t         clr_cmd_i,
    input  logic [FLAG_W-1:0] set_i,
    output logic [FLAG_W-1:0] flags_o
);
    logic [FLAG_W-1:0] clr_mask;

    // Expand the command bits into the flags they clear.
    always_comb begin
        clr_mask = clr_we_i ? FLAG_W'(flag_clear_mask(clr_cmd_i)) : '0;
    end

    // Update flags: clear first, then apply the set pulses on top.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= (flags_o & ~clr_mask) | set_i;
    end
endmodule

// File: rtl/imgdec_field_reg.sv
// Host-written field: holds FIELD_W bits, and the low ZERO_LSBS bits always
// read as zero. The caller passes in only the bus bits that are stored.
module imgdec_field_reg #(
    parameter int FIELD_W   = 16,
    parameter int ZERO_LSBS = 0,
    localparam int STORE_W  = FIELD_W - ZERO_LSBS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [STORE_W-1:0] d_i,
    output logic [FIELD_W-1:0] q_o
);
    logic [STORE_W-1:0] hi_q;

    // Load the stored bits on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)    hi_q <= '0;
        else if (we_i) hi_q <= d_i;
    end

    generate
        if (ZERO_LSBS > 0) begin : g_aligned
            // Append the forced-zero low bits.
            always_comb q_o = {hi_q, {ZERO_LSBS{1'b0}}};
        end else begin : g_plain
            // Present the stored bits unchanged.
            always_comb q_o = hi_q;
        end
    endgenerate
endmodule

// File: rtl/imgdec_read_mux.sv
// Read multiplexer: picks the register at the given word offset and
// zero-extends narrow values to the bus width. Unmapped offsets read 0.
module imgdec_read_mux
    import imgdec_regfile_pkg::*;
#(
    parameter int A_W  = ADR_W,
    parameter int D_W  = BUS_W,
    parameter int H_W  = HALF_W,
    parameter int F_W  = FLAG_N
) (
    input  logic [A_W-1:0] adr_i,
    input  logic [F_W-1:0] flags_i,
    input  logic [F_W-1:0] irq_en_i,
    input  logic [H_W-1:0] img_w_i,
    input  logic [H_W-1:0] img_h_i,
    input  logic [H_W-1:0] crop_x0_i,
    input  logic [H_W-1:0] crop_y0_i,
    input  logic [H_W-1:0] crop_x1_i,
    input  logic [H_W-1:0] crop_y1_i,
    input  logic [D_W-1:0] src_base_i,
    input  logic [D_W-1:0] src_len_i,
    input  logic [D_W-1:0] dst_base_i,
    input  logic [D_W-1:0] dst_limit_i,
    input  logic [D_W-1:0] dst_offset_i,
    input  logic [H_W-1:0] dst_width_i,
    input  logic [D_W-1:0] dst_ptr_i,
    output logic [D_W-1:0] rd_o
);
    // Select the addressed register, zero-extended.
    always_comb begin
        rd_o = '0;
        case (adr_i)
            A_W'(OFS_FLAGS):      rd_o = D_W'(flags_i);
            A_W'(OFS_IRQ_EN):     rd_o = D_W'(irq_en_i);
            A_W'(OFS_IMG_W):      rd_o = D_W'(img_w_i);
            A_W'(OFS_IMG_H):      rd_o = D_W'(img_h_i);
            A_W'(OFS_CROP_X0):    rd_o = D_W'(crop_x0_i);
            A_W'(OFS_CROP_Y0):    rd_o = D_W'(crop_y0_i);
            A_W'(OFS_CROP_X1):    rd_o = D_W'(crop_x1_i);
            A_W'(OFS_CROP_Y1):    rd_o = D_W'(crop_y1_i);
            A_W'(OFS_SRC_BASE):   rd_o = src_base_i;
            A_W'(OFS_SRC_LEN):    rd_o = src_len_i;
            A_W'(OFS_DST_BASE):   rd_o = dst_base_i;
            A_W'(OFS_DST_LIMIT):  rd_o = dst_limit_i;
            A_W'(OFS_DST_OFFSET): rd_o = dst_offset_i;
            A_W'(OFS_DST_WIDTH):  rd_o = D_W'(dst_width_i);
            A_W'(OFS_DST_PTR):    rd_o = dst_ptr_i;
            default:              rd_o = '0;
        endcase
    end
endmodule

// File: rtl/imgdec_regfile.sv
// Decoder control register file (top). Decodes Wishbone writes into the
// shaped configuration fields, holds the event flags and drives the
// interrupt. Assumes a 32-bit bus, 16-bit coordinates and eight flags.
module imgdec_regfile
    import imgdec_regfile_pkg::*;
#(
    parameter int A_W = ADR_W,
    parameter int D_W = BUS_W,
    parameter int H_W = HALF_W,
    parameter int F_W = FLAG_N
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wb_cyc_i,
    input  logic           wb_stb_i,
    input  logic           wb_we_i,
    input  logic [A_W-1:0] wb_adr_i,
    input  logic [D_W-1:0] wb_dat_i,
    output logic [D_W-1:0] wb_dat_o,
    output logic           wb_ack_o,
    input  logic [F_W-1:0] flag_set_i,
    input  logic [H_W-1:0] img_w_i,
    input  logic [H_W-1:0] img_h_i,
    input  logic [D_W-1:0] dst_ptr_i,
    output logic [H_W-1:0] crop_x0_o,
    output logic [H_W-1:0] crop_y0_o,
    output logic [H_W-1:0] crop_x1_o,
    output logic [H_W-1:0] crop_y1_o,
    output logic [D_W-1:0] src_base_o,
    output logic [D_W-1:0] src_len_o,
    output logic [D_W-1:0] dst_base_o,
    output logic [D_W-1:0] dst_limit_o,
    output logic [D_W-1:0] dst_offset_o,
    output logic [H_W-1:0] dst_width_o,
    output logic           irq_o
);
    logic           req_wr;
    logic [D_W-1:0] rd_data;
    logic [F_W-1:0] flags_q;
    logic [F_W-1:0] irq_en_q;
    flag_clr_t      clr_cmd;
    logic           we_flags, we_irq_en, we_cx0, we_cy0, we_cx1, we_cy1;
    logic           we_sbase, we_slen, we_dbase, we_dlim, we_doff, we_dwid;

    imgdec_bus_front #(.BUS_W(D_W)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_i     (wb_cyc_i),
        .stb_i     (wb_stb_i),
        .we_i      (wb_we_i),
        .rd_data_i (rd_data),
        .req_wr_o  (req_wr),
        .ack_o     (wb_ack_o),
        .dat_o     (wb_dat_o)
    );

    // Per-register write enables from the accepted write and its offset.
    always_comb begin
        we_flags  = req_wr && (wb_adr_i == A_W'(OFS_FLAGS));
        we_irq_en = req_wr && (wb_adr_i == A_W'(OFS_IRQ_EN));
        we_cx0    = req_wr && (wb_adr_i == A_W'(OFS_CROP_X0));
        we_cy0    = req_wr && (wb_adr_i == A_W'(OFS_CROP_Y0));
        we_cx1    = req_wr && (wb_adr_i == A_W'(OFS_CROP_X1));
        we_cy1    = req_wr && (wb_adr_i == A_W'(OFS_CROP_Y1));
        we_sbase  = req_wr && (wb_adr_i == A_W'(OFS_SRC_BASE));
        we_slen   = req_wr && (wb_adr_i == A_W'(OFS_SRC_LEN));
        we_dbase  = req_wr && (wb_adr_i == A_W'(OFS_DST_BASE));
        we_dlim   = req_wr && (wb_adr_i == A_W'(OFS_DST_LIMIT));
        we_doff   = req_wr && (wb_adr_i == A_W'(OFS_DST_OFFSET));
        we_dwid   = req_wr && (wb_adr_i == A_W'(OFS_DST_WIDTH));
    end

    // Pick the clear command bits out of the write word.
    always_comb begin
        clr_cmd.grp_a = wb_dat_i[8];
        clr_cmd.grp_b = wb_dat_i[7];
        clr_cmd.one_2 = wb_dat_i[2];
        clr_cmd.one_1 = wb_dat_i[1];
    end

    imgdec_flag_bank #(.FLAG_W(F_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_we_i  (we_flags),
        .clr_cmd_i (clr_cmd),
        .set_i     (flag_set_i),
        .flags_o   (flags_q)
    );

    // Interrupt enables: bus bits F_W..1 line up with flags F_W..1.
    imgdec_field_reg #(.FIELD_W(F_W), .ZERO_LSBS(0)) u_irq_en (
        .clk(clk), .rst_n(rst_n), .we_i(we_irq_en),
        .d_i(wb_dat_i[F_W:1]), .q_o(irq_en_q)
    );

    // Even-only X coordinates and line width.
    imgdec_field_reg #(.FIELD_W(H_W), .ZERO_LSBS(1)) u_cx0 (
        .clk(clk), .rst_n(rst_n), .we_i(we_cx0),
        .d_i(wb_dat_i[H_W-1:1]), .q_o(crop_x0_o)
    );
    imgdec_field_reg #(.FIELD_W(H_W), .ZERO_LSBS(1)) u_cx1 (
        .clk(clk), .rst_n(rst_n), .we_i(we_cx1),
        .d_i(wb_dat_i[H_W-1:1]), .q_o(crop_x1_o)
    );
    imgdec_field_reg #(.FIELD_W(H_W), .ZERO_LSBS(1)) u_dwid (
        .clk(clk), .rst_n(rst_n), .we_i(we_dwid),
        .d_i(wb_dat_i[H_W-1:1]), .q_o(dst_width_o)
    );

    // Unshaped Y coordinates.
    imgdec_field_reg #(.FIELD_W(H_W), .ZERO_LSBS(0)) u_cy0 (
        .clk(clk), .rst_n(rst_n), .we_i(we_cy0),
        .d_i(wb_dat_i[H_W-1:0]), .q_o(crop_y0_o)
    );
    imgdec_field_reg #(.FIELD_W(H_W), .ZERO_LSBS(0)) u_cy1 (
        .clk(clk), .rst_n(rst_n), .we_i(we_cy1),
        .d_i(wb_dat_i[H_W-1:0]), .q_o(crop_y1_o)
    );

    // Full-width source address and length.
    imgdec_field_reg #(.FIELD_W(D_W), .ZERO_LSBS(0)) u_sbase (
        .clk(clk), .rst_n(rst_n), .we_i(we_sbase),
        .d_i(wb_dat_i), .q_o(src_base_o)
    );
    imgdec_field_reg #(.FIELD_W(D_W), .ZERO_LSBS(0)) u_slen (
        .clk(clk), .rst_n(rst_n), .we_i(we_slen),
        .d_i(wb_dat_i), .q_o(src_len_o)
    );

    // Word-aligned output buffer addresses.
    imgdec_field_reg #(.FIELD_W(D_W), .ZERO_LSBS(2)) u_dbase (
        .clk(clk), .rst_n(rst_n), .we_i(we_dbase),
        .d_i(wb_dat_i[D_W-1:2]), .q_o(dst_base_o)
    );
    imgdec_field_reg #(.FIELD_W(D_W), .ZERO_LSBS(2)) u_dlim (
        .clk(clk), .rst_n(rst_n), .we_i(we_dlim),
        .d_i(wb_dat_i[D_W-1:2]), .q_o(dst_limit_o)
    );
    imgdec_field_reg #(.FIELD_W(D_W), .ZERO_LSBS(2)) u_doff (
        .clk(clk), .rst_n(rst_n), .we_i(we_doff),
        .d_i(wb_dat_i[D_W-1:2]), .q_o(dst_offset_o)
    );

    imgdec_read_mux #(.A_W(A_W), .D_W(D_W), .H_W(H_W), .F_W(F_W)) u_rmux (
        .adr_i        (wb_adr_i),
        .flags_i      (flags_q),
        .irq_en_i     (irq_en_q),
        .img_w_i      (img_w_i),
        .img_h_i      (img_h_i),
        .crop_x0_i    (crop_x0_o),
        .crop_y0_i    (crop_y0_o),
        .crop_x1_i    (crop_x1_o),
        .crop_y1_i    (crop_y1_o),
        .src_base_i   (src_base_o),
        .src_len_i    (src_len_o),
        .dst_base_i   (dst_base_o),
        .dst_limit_i  (dst_limit_o),
        .dst_offset_i (dst_offset_o),
        .dst_width_i  (dst_width_o),
        .dst_ptr_i    (dst_ptr_i),
        .rd_o         (rd_data)
    );

    // Interrupt while any enabled flag is set.
    always_comb irq_o = |(flags_q & irq_en_q);

endmodule

// File: rtl/imgdec_regfile_chk.sv
// Checker for the decoder control register file, bound to the top module.
// It observes ports and the flag and enable state.
module imgdec_regfile_chk #(
    parameter int A_W = 4,
    parameter int D_W = 32,
    parameter int H_W = 16,
    parameter int F_W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wb_cyc_i,
    input logic           wb_stb_i,
    input logic           wb_we_i,
    input logic [A_W-1:0] wb_adr_i,
    input logic [D_W-1:0] wb_dat_i,
    input logic [D_W-1:0] wb_dat_o,
    input logic           wb_ack_o,
    input logic [F_W-1:0] flag_set_i,
    input logic [F_W-1:0] flags_q,
    input logic [F_W-1:0] irq_en_q,
    input logic [H_W-1:0] crop_x0_o,
    input logic [H_W-1:0] crop_y0_o,
    input logic [D_W-1:0] src_base_o,
    input logic [D_W-1:0] dst_base_o,
    input logic [H_W-1:0] dst_width_o,
    input logic           irq_o
);
    logic req, wr;
    always_comb begin
        req = wb_cyc_i && wb_stb_i && !wb_ack_o;
        wr  = req && wb_we_i;
    end

    p_ack_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> wb_ack_o);
    p_ack_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack_o |=> !wb_ack_o);
    p_flag_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req && !wb_we_i && (wb_adr_i == A_W'(0)) |=> (wb_dat_o[D_W-1:F_W] == '0));
    p_grp_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr && (wb_adr_i == A_W'(0)) && wb_dat_i[8] && (flag_set_i == '0)
        |=> (flags_q[5:0] == '0));
    p_grp_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr && (wb_adr_i == A_W'(0)) && wb_dat_i[7] && (flag_set_i == '0)
        |=> (flags_q[5:0] == '0) && !flags_q[7]);
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set_i != '0) |=> ((flags_q & $past(flag_set_i)) == $past(flag_set_i)));
    p_x_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr && (wb_adr_i == A_W'(4)) |=> (crop_x0_o == {$past(wb_dat_i[H_W-1:1]), 1'b0}));
    p_word_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr && (wb_adr_i == A_W'(10)) |=> (dst_base_o == {$past(wb_dat_i[D_W-1:2]), 2'b00}));
    p_ro_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr && ((wb_adr_i == A_W'(2)) || (wb_adr_i == A_W'(3)) ||
               (wb_adr_i == A_W'(14)) || (wb_adr_i == A_W'(15)))
        |=> $stable(crop_x0_o) && $stable(crop_y0_o) && $stable(src_base_o) &&
            $stable(dst_base_o) && $stable(dst_width_o) && $stable(irq_en_q));
    p_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_set_i & irq_en_q) != '0) && !(wr && (wb_adr_i == A_W'(1))) |=> irq_o);
endmodule

bind imgdec_regfile imgdec_regfile_chk #(.A_W(A_W), .D_W(D_W), .H_W(H_W), .F_W(F_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i),
    .wb_we_i(wb_we_i), .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i),
    .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o), .flag_set_i(flag_set_i),
    .flags_q(flags_q), .irq_en_q(irq_en_q), .crop_x0_o(crop_x0_o),
    .crop_y0_o(crop_y0_o), .src_base_o(src_base_o), .dst_base_o(dst_base_o),
    .dst_width_o(dst_width_o), .irq_o(irq_o)
);

// File: tb/imgdec_regfile_bench.sv
// Directed bench for the decoder control register file.
module imgdec_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [3:0]  adr = '0;
    logic [31:0] dat_i = '0;
    logic [31:0] dat_o;
    logic        ack;
    logic [7:0]  fset = '0;
    logic [15:0] img_w = 16'h0280, img_h = 16'h01E0;
    logic [31:0] dptr = 32'h8000_1234;
    logic [15:0] cx0, cy0, cx1, cy1, dwid;
    logic [31:0] sbase, slen, dbase, dlim, doff;
    logic        irq;
    int checks = 0, fails = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    imgdec_regfile u_imgdec_regfile (
        .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_dat_i(dat_i), .wb_dat_o(dat_o), .wb_ack_o(ack),
        .flag_set_i(fset), .img_w_i(img_w), .img_h_i(img_h), .dst_ptr_i(dptr),
        .crop_x0_o(cx0), .crop_y0_o(cy0), .crop_x1_o(cx1), .crop_y1_o(cy1),
        .src_base_o(sbase), .src_len_o(slen), .dst_base_o(dbase),
        .dst_limit_o(dlim), .dst_offset_o(doff), .dst_width_o(dwid), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; cyc = 0; stb = 0; fset = '0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // One write; the set vector is driven in the same cycle as the request.
    task automatic wb_wr(input logic [3:0] a, input logic [31:0] d, input logic [7:0] s);
        @(negedge clk); cyc = 1; stb = 1; we = 1; adr = a; dat_i = d; fset = s;
        @(negedge clk);
        check("R1 ack after write", 32'(ack), 32'd1);
        cyc = 0; stb = 0; we = 0; fset = '0;
        @(negedge clk);
        check("R1 ack single cycle", 32'(ack), 32'd0);
    endtask

    task automatic wb_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); cyc = 1; stb = 1; we = 0; adr = a;
        @(negedge clk);
        d = dat_o;
        cyc = 0; stb = 0;
    endtask

    task automatic pulse_set(input logic [7:0] s);
        @(negedge clk); fset = s;
        @(negedge clk); fset = '0;
    endtask

    task automatic t_reset_r13();
        do_reset();
        check("R13 ack low", 32'(ack), 0);
        check("R13 irq low", 32'(irq), 0);
        wb_rd(4'd0, rv);  check("R13 flags", rv, 0);
        wb_rd(4'd1, rv);  check("R13 irq_en", rv, 0);
        wb_rd(4'd8, rv);  check("R13 src_base", rv, 0);
        check("R13 dst_limit port", dlim, 0);
    endtask

    task automatic t_group_clear_r4();
        do_reset(); pulse_set(8'hFF);
        wb_rd(4'd0, rv); check("R3 all flags set", rv, 32'h0000_00FF);
        wb_wr(4'd0, 32'h0000_0100, 8'h00);
        wb_rd(4'd0, rv); check("R4 bit8 clears 6..1", rv, 32'h0000_00C0);
        pulse_set(8'hFF);
        wb_wr(4'd0, 32'h0000_0080, 8'h00);
        wb_rd(4'd0, rv); check("R4 bit7 clears 8 and 6..1", rv, 32'h0000_0040);
    endtask

    task automatic t_single_clear_r5();
        do_reset(); pulse_set(8'hFF);
        wb_wr(4'd0, 32'h0000_0004, 8'h00);
        wb_rd(4'd0, rv); check("R5 bit2 clears flag 2", rv, 32'h0000_00FD);
        pulse_set(8'hFF);
        wb_wr(4'd0, 32'h0000_0002, 8'h00);
        wb_rd(4'd0, rv); check("R5 bit1 clears flag 1", rv, 32'h0000_00FE);
        pulse_set(8'hFF);
        wb_wr(4'd0, 32'hFFFF_FE79, 8'h00);
        wb_rd(4'd0, rv); check("R5 other bits keep flags", rv, 32'h0000_00FF);
        wb_wr(4'd0, 32'h0000_0186, 8'h00);
        wb_rd(4'd0, rv); check("R5 flag 7 survives all clears", rv, 32'h0000_0040);
    endtask

    task automatic t_set_priority_r6();
        do_reset(); pulse_set(8'hFF);
        wb_wr(4'd0, 32'h0000_0080, 8'h01);
        wb_rd(4'd0, rv); check("R6 set beats clear", rv, 32'h0000_0041);
    endtask

    task automatic t_shaping_r7_r8_r9();
        do_reset();
        wb_wr(4'd4, 32'hFFFF_FFFF, 8'h00);
        wb_rd(4'd4, rv); check("R7 crop_x0 even", rv, 32'h0000_FFFE);
        wb_wr(4'd6, 32'h1357_2469, 8'h00);
        check("R7 crop_x1 port", 32'(cx1), 32'h0000_2468);
        wb_wr(4'd13, 32'h0000_0321, 8'h00);
        wb_rd(4'd13, rv); check("R7 dst_width", rv, 32'h0000_0320);
        wb_wr(4'd10, 32'hDEAD_BEEF, 8'h00);
        wb_rd(4'd10, rv); check("R8 dst_base aligned", rv, 32'hDEAD_BEEC);
        wb_wr(4'd11, 32'hFFFF_FFFF, 8'h00);
        check("R8 dst_limit port", dlim, 32'hFFFF_FFFC);
        wb_wr(4'd12, 32'h0000_0007, 8'h00);
        wb_rd(4'd12, rv); check("R8 dst_offset", rv, 32'h0000_0004);
        wb_wr(4'd5, 32'h1234_ABCD, 8'h00);
        wb_rd(4'd5, rv); check("R9 crop_y0 zext", rv, 32'h0000_ABCD);
        wb_wr(4'd7, 32'hFFFF_0001, 8'h00);
        check("R9 crop_y1 port", 32'(cy1), 32'h0000_0001);
        wb_wr(4'd8, 32'hA5A5_3C3F, 8'h00);
        wb_rd(4'd8, rv); check("R9 src_base full", rv, 32'hA5A5_3C3F);
        wb_wr(4'd9, 32'h0000_0003, 8'h00);
        wb_rd(4'd9, rv); check("R9 src_len full", rv, 32'h0000_0003);
    endtask

    task automatic t_irq_r10_r12();
        do_reset();
        wb_wr(4'd1, 32'h0000_01FF, 8'h00);
        wb_rd(4'd1, rv); check("R10 irq_en bits 8..1", rv, 32'h0000_00FF);
        wb_wr(4'd1, 32'h0000_0001, 8'h00);
        wb_rd(4'd1, rv); check("R10 bit0 dropped", rv, 32'h0000_0000);
        wb_wr(4'd1, 32'h0000_0004, 8'h00);
        pulse_set(8'h01);
        check("R12 unenabled flag no irq", 32'(irq), 0);
        pulse_set(8'h02);
        check("R12 enabled flag irq", 32'(irq), 1);
        wb_wr(4'd0, 32'h0000_0004, 8'h00);
        check("R12 irq drops after clear", 32'(irq), 0);
    endtask

    task automatic t_readonly_r11_r2();
        do_reset();
        wb_wr(4'd4, 32'h0000_0010, 8'h00);
        wb_wr(4'd2, 32'h0000_5555, 8'h00);
        wb_rd(4'd2, rv); check("R11 img_w read only", rv, 32'h0000_0280);
        wb_wr(4'd3, 32'h0000_5555, 8'h00);
        wb_rd(4'd3, rv); check("R11 img_h read only", rv, 32'h0000_01E0);
        wb_wr(4'd14, 32'h0000_0000, 8'h00);
        wb_rd(4'd14, rv); check("R11 dst_ptr read only", rv, 32'h8000_1234);
        wb_wr(4'd15, 32'hFFFF_FFFF, 8'h00);
        wb_rd(4'd15, rv); check("R2 unmapped reads 0", rv, 0);
        wb_rd(4'd4, rv); check("R11 crop_x0 untouched", rv, 32'h0000_0010);
        wb_rd(4'd1, rv); check("R11 irq_en untouched", rv, 0);
        check("R11 dst_base untouched", dbase, 0);
    endtask

    initial begin
        t_reset_r13();
        t_group_clear_r4();
        t_single_clear_r5();
        t_set_priority_r6();
        t_shaping_r7_r8_r9();
        t_irq_r10_r12();
        t_readonly_r11_r2();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule